// File: doc/BRIEF.md
# 8x8 Inverse DCT Bus Peripheral

This block is a memory-mapped slave that turns one 8x8 block of signed frequency coefficients into 64 unsigned 8-bit pixels. The host stores the coefficients one 32-bit word at a time. Each row goes through the one-dimensional transform as soon as its eighth coefficient is written. The transformed row replaces the coefficients in the same storage, and this work overlaps with the host writing the next row. Once all eight rows are transformed, the eight column transforms run back to back. They use the same arithmetic datapath as the rows, with a different scaling and with saturation.

Both storage arrays are flip-flop register files, so the sequencer and the bus can reach any element in any cycle. The host can read the intermediate row results as 32-bit words and the final pixels as bytes. A status word tells the host when the column pass has finished. Every bus access goes through a three-state slave machine and takes three clock cycles.

Top module: `idct8x8_slave`

## Requirements
- R1: After reset, ack_o and rdata_o are 0, the done bit (bit 0 of the word at 0x000) is 0, and every pixel byte reads 0.
- R2: The slave machine cycles through idle, transfer and acknowledge. A select seen while idle gives ack_o high for exactly one cycle, in the third cycle of the select, so back-to-back transactions are three cycles apart. The access happens at the transfer-to-acknowledge edge.
- R3: A write to byte address 0x100 + 4*(8*r + c) stores coefficient row r, column c. Reads in 0x100..0x1FF return the stored word.
- R4: Row pass on input v0..v7, with constants 2841, 2676, 2408, 1609, 1108, 565 (scaled by 2048). DC and v4 are shifted left by 11 and 128 is added to DC. There is no rounding of the products. Each output is shifted arithmetically right by 8. Result (r, c) is written in place and reads at 0x200 + 4*(8*r + c).
- R5: Writing column 7 of row r starts that row's transform. A read of row r that begins right after that write already returns the transformed value.
- R6: Column pass on row results. DC and v4 are shifted left by 8 and 8192 is added to DC. Products get +4 and an arithmetic right shift by 3. Each output is shifted right by 14, offset by +128 and saturated to 0..255. Pixel (r, c) reads as a zero-extended byte at 0x300 + 8*r + c.
- R7: Columns run in order 0 to 7 after row 7, at two cycles each. The done bit reads 0 in the first six back-to-back status reads after the final coefficient write and reads 1 in the seventh.
- R8: A write to 0x100 clears the done bit.
- R9: Writes outside 0x100..0x1FF change no stored value and do not change the done bit.
- R10: Reads of 0x001..0x0FF and 0x340..0x3FF return 0.
- R11: A DC-only block saturates to all 255 for DC 2000 and to all 0 for DC -2000. DC 80 gives row value 640 and pixel 138.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Transaction select, held until ack_o |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-cycle transaction acknowledge |
| rdata_o | output | 32 | Read data, valid while ack_o is high |

## Verification
A write or read acts on the edge between transfer and acknowledge, and the bench samples rdata_o on the falling edge of the acknowledge cycle. It also counts falling edges from select to acknowledge: two from idle and three back to back. A row result lands two edges after its last coefficient write, so the read issued straight after that write must already see it. The column pass ends nineteen edges after the final write. The bench therefore expects the done bit to be 0 in six successive status reads and to be 1 in the seventh. Expected row and pixel values come from an integer model of the two passes in the bench.

// File: rtl/idct_pkg.sv
package idct_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 8;
  localparam int NPT    = 8;
  // cos constants, scale 2048
  localparam int K1 = 2841;
  localparam int K2 = 2676;
  localparam int K3 = 2408;
  localparam int K5 = 1609;
  localparam int K6 = 1108;
  localparam int K7 = 565;
  typedef logic signed [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {BS_IDLE, BS_XFER, BS_ACK} bus_st_e;
endpackage

// File: rtl/idct_bus.sv
module idct_bus
  import idct_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic xfer_o,
  output logic ack_o
);
  bus_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= BS_IDLE;
    else begin
      case (st_q)
        BS_IDLE: if (sel_i) st_q <= BS_XFER;
        BS_XFER: st_q <= BS_ACK;
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  assign xfer_o = (st_q == BS_XFER);
  assign ack_o  = (st_q == BS_ACK);
endmodule

// File: rtl/idct_core.sv
module idct_core
  import idct_pkg::*;
#(
  localparam int LW = $clog2(NPT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          col_i,
  input  logic [LW-1:0] idx_i,
  input  word_t         vec_i [NPT],
  output logic          valid_o,
  output logic          col_o,
  output logic [LW-1:0] idx_o,
  output word_t         res_o [NPT]
);
  // stage 1: pre-scale, rotations, DC/v4 butterfly
  word_t x0, x1, ra, rb, rc, rnd;
  word_t d_e0, d_e1, d_p2, d_p3, d_p4, d_p5, d_p6, d_p7;
  logic [3:0] pre;
  logic [1:0] msh;

  always_comb begin
    pre  = col_i ? 4'd8 : 4'd11;
    msh  = col_i ? 2'd3 : 2'd0;
    rnd  = col_i ? 32'sd4 : 32'sd0;
    x0   = (vec_i[0] <<< pre) + (col_i ? 32'sd8192 : 32'sd128);
    x1   = vec_i[4] <<< pre;
    ra   = K7 * (vec_i[1] + vec_i[7]) + rnd;
    rb   = K3 * (vec_i[5] + vec_i[3]) + rnd;
    rc   = K6 * (vec_i[2] + vec_i[6]) + rnd;
    d_p4 = (ra + (K1 - K7) * vec_i[1]) >>> msh;
    d_p5 = (ra - (K1 + K7) * vec_i[7]) >>> msh;
    d_p6 = (rb - (K3 - K5) * vec_i[5]) >>> msh;
    d_p7 = (rb - (K3 + K5) * vec_i[3]) >>> msh;
    d_p2 = (rc - (K2 + K6) * vec_i[6]) >>> msh;
    d_p3 = (rc + (K2 - K6) * vec_i[2]) >>> msh;
    d_e0 = x0 + x1;
    d_e1 = x0 - x1;
  end

  word_t s_e0, s_e1, s_p2, s_p3, s_p4, s_p5, s_p6, s_p7;
  logic s_v, s_col;
  logic [LW-1:0] s_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_v <= 1'b0; s_col <= 1'b0; s_idx <= '0;
      s_e0 <= '0; s_e1 <= '0; s_p2 <= '0; s_p3 <= '0;
      s_p4 <= '0; s_p5 <= '0; s_p6 <= '0; s_p7 <= '0;
    end else begin
      s_v <= start_i;
      if (start_i) begin
        s_col <= col_i; s_idx <= idx_i;
        s_e0 <= d_e0; s_e1 <= d_e1; s_p2 <= d_p2; s_p3 <= d_p3;
        s_p4 <= d_p4; s_p5 <= d_p5; s_p6 <= d_p6; s_p7 <= d_p7;
      end
    end
  end

  // stage 2: odd/even combine, output scaling
  word_t o1, o4, o5, o6, t0, t3, t7, t8, q2, q4, sat;
  word_t y [NPT];

  always_comb begin
    o1 = s_p4 + s_p6;
    o4 = s_p4 - s_p6;
    o6 = s_p5 + s_p7;
    o5 = s_p5 - s_p7;
    t7 = s_e0 + s_p3;
    t8 = s_e0 - s_p3;
    t3 = s_e1 + s_p2;
    t0 = s_e1 - s_p2;
    q2 = (181 * (o4 + o5) + 128) >>> 8;
    q4 = (181 * (o4 - o5) + 128) >>> 8;
    y[0] = t7 + o1;  y[7] = t7 - o1;
    y[1] = t3 + q2;  y[6] = t3 - q2;
    y[2] = t0 + q4;  y[5] = t0 - q4;
    y[3] = t8 + o6;  y[4] = t8 - o6;
    sat = '0;
    for (int k = 0; k < NPT; k++) begin
      if (s_col) begin
        sat = (y[k] >>> 14) + 32'sd128;
        if (sat < 0) res_o[k] = '0;
        else if (sat > 32'sd255) res_o[k] = 32'sd255;
        else res_o[k] = sat;
      end else begin
        res_o[k] = y[k] >>> 8;
      end
    end
  end

  assign valid_o = s_v;
  assign col_o   = s_col;
  assign idx_o   = s_idx;
endmodule

// File: rtl/idct8x8_slave.sv
module idct8x8_slave
  import idct_pkg::*;
#(
  parameter int AW      = 10,
  parameter int WIN_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int NE = NPT * NPT;
  localparam int LW = $clog2(NPT);
  localparam int IW = $clog2(NE);
  localparam logic [1:0] WIN_STAT = 2'd0;
  localparam logic [1:0] WIN_COEF = 2'd1;
  localparam logic [1:0] WIN_ROW  = 2'd2;
  localparam logic [LW-1:0] LAST  = LW'(NPT - 1);

  word_t blk_q [NE];
  logic [PIX_W-1:0] pix_q [NE];
  logic [NPT-1:0] pend_q, pend_n, rdone_q;
  logic busy_q, col_run_q, done_q;
  logic [LW-1:0] col_idx_q, row_sel, iss_idx;
  logic [WORD_W-1:0] rdata_q, rd_mux;

  logic xfer, wr_coef, clr, has_pend, issue, issue_col, start_cols;
  logic [1:0] win;
  logic [IW-1:0] widx;
  word_t vec [NPT];
  logic core_v, core_col;
  logic [LW-1:0] core_idx;
  word_t core_res [NPT];

  idct_bus u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .xfer_o (xfer),
    .ack_o  (ack_o)
  );

  assign win     = addr_i[WIN_LSB+1:WIN_LSB];
  assign widx    = addr_i[IW+1:2];
  assign wr_coef = xfer && we_i && (win == WIN_COEF);
  assign clr     = wr_coef && (widx == '0);

  // job selection: pending rows first, then the column sweep
  always_comb begin
    row_sel  = '0;
    has_pend = |pend_q;
    for (int i = NPT - 1; i >= 0; i--) if (pend_q[i]) row_sel = LW'(i);
    issue      = !busy_q && (has_pend || col_run_q);
    issue_col  = !has_pend;
    iss_idx    = issue_col ? col_idx_q : row_sel;
    start_cols = !col_run_q && !done_q && !busy_q && !has_pend && (&rdone_q);
    for (int k = 0; k < NPT; k++)
      vec[k] = issue_col ? blk_q[{LW'(k), col_idx_q}] : blk_q[{row_sel, LW'(k)}];
    pend_n = pend_q;
    if (issue && !issue_col) pend_n[row_sel] = 1'b0;
    if (wr_coef && (widx[LW-1:0] == LAST)) pend_n[widx[IW-1:LW]] = 1'b1;
  end

  idct_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue),
    .col_i   (issue_col),
    .idx_i   (iss_idx),
    .vec_i   (vec),
    .valid_o (core_v),
    .col_o   (core_col),
    .idx_o   (core_idx),
    .res_o   (core_res)
  );

  always_comb begin
    rd_mux = '0;
    case (win)
      WIN_STAT: if (addr_i[WIN_LSB-1:0] == '0) rd_mux = {{(WORD_W-1){1'b0}}, done_q};
      WIN_COEF, WIN_ROW: rd_mux = blk_q[widx];
      default: if (addr_i[WIN_LSB-1:IW] == '0)
        rd_mux = {{(WORD_W-PIX_W){1'b0}}, pix_q[addr_i[IW-1:0]]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NE; i++) begin
        blk_q[i] <= '0;
        pix_q[i] <= '0;
      end
      pend_q <= '0; rdone_q <= '0; busy_q <= 1'b0; col_run_q <= 1'b0;
      done_q <= 1'b0; col_idx_q <= '0; rdata_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (wr_coef) blk_q[widx] <= wdata_i;
      if (core_v) begin
        for (int k = 0; k < NPT; k++) begin
          if (core_col) pix_q[{LW'(k), core_idx}] <= core_res[k][PIX_W-1:0];
          else          blk_q[{core_idx, LW'(k)}] <= core_res[k];
        end
      end
      if (issue) busy_q <= 1'b1;
      else if (core_v) busy_q <= 1'b0;
      if (clr) rdone_q <= '0;
      else if (core_v && !core_col) rdone_q[core_idx] <= 1'b1;
      if (start_cols) begin
        col_run_q <= 1'b1;
        col_idx_q <= '0;
      end else if (issue && issue_col) begin
        col_idx_q <= col_idx_q + 1'b1;
      end
      if (core_v && core_col && core_idx == LAST) col_run_q <= 1'b0;
      if (clr) done_q <= 1'b0;
      else if (core_v && core_col && core_idx == LAST) done_q <= 1'b1;
      if (xfer) rdata_q <= we_i ? '0 : rd_mux;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/idct_chk.sv
module idct_chk
  import idct_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sel_i,
  input logic           ack_o,
  input logic           xfer,
  input logic           clr,
  input logic           done_q,
  input logic           issue,
  input logic           core_v,
  input logic           core_col,
  input logic           col_run_q,
  input logic [NPT-1:0] rdone_q
);
  a_r2_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r2_ack_after_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(xfer) && $past(sel_i));
  a_r8_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !done_q);
  a_r7_cols_after_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_run_q |-> (&rdone_q));
  a_r5_core_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_v |-> $past(issue));
  a_r7_done_from_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(core_v) && $past(core_col));
endmodule

bind idct8x8_slave idct_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .ack_o     (ack_o),
  .xfer      (xfer),
  .clr       (clr),
  .done_q    (done_q),
  .issue     (issue),
  .core_v    (core_v),
  .core_col  (core_col),
  .col_run_q (col_run_q),
  .rdone_q   (rdone_q)
);

// File: tb/sim_idct8x8_slave.sv
`timescale 1ns/1ps
module sim_idct8x8_slave;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ack_o;
  logic [31:0] rdata_o;

  idct8x8_slave u0 (.*);

  always #4 clk_i = ~clk_i;

  typedef int v8_t [8];
  int n_chk = 0, n_bad = 0, last_cyc = 0;
  bit finished = 0;
  logic [31:0] rd_v;
  int coef [64], rrow [64], rpix [64];

  // seed, dc, ac amplitude, frequency span (r+c < span)
  localparam int TV [6][4] = '{
    '{3, 0, 0, 0}, '{7, 120, 40, 4}, '{11, -300, 200, 8},
    '{19, 512, 60, 2}, '{5, 1023, 1023, 16}, '{23, -64, 15, 6}};

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic v8_t ref1d(v8_t v, bit col);
    int x0, x1, x2, x3, x4, x5, x6, x7, x8, s, rn, m, t;
    v8_t o;
    s = col ? 8 : 11; rn = col ? 4 : 0; m = col ? 3 : 0;
    x1 = v[4] <<< s; x2 = v[6]; x3 = v[2]; x4 = v[1]; x5 = v[7]; x6 = v[5]; x7 = v[3];
    x0 = (v[0] <<< s) + (col ? 8192 : 128);
    x8 = 565 * (x4 + x5) + rn;
    x4 = (x8 + (2841 - 565) * x4) >>> m;
    x5 = (x8 - (2841 + 565) * x5) >>> m;
    x8 = 2408 * (x6 + x7) + rn;
    x6 = (x8 - (2408 - 1609) * x6) >>> m;
    x7 = (x8 - (2408 + 1609) * x7) >>> m;
    x8 = x0 + x1; x0 = x0 - x1;
    x1 = 1108 * (x3 + x2) + rn;
    x2 = (x1 - (2676 + 1108) * x2) >>> m;
    x3 = (x1 + (2676 - 1108) * x3) >>> m;
    x1 = x4 + x6; x4 = x4 - x6; x6 = x5 + x7; x5 = x5 - x7;
    x7 = x8 + x3; x8 = x8 - x3; x3 = x0 + x2; x0 = x0 - x2;
    x2 = (181 * (x4 + x5) + 128) >>> 8;
    x4 = (181 * (x4 - x5) + 128) >>> 8;
    o[0] = x7 + x1; o[1] = x3 + x2; o[2] = x0 + x4; o[3] = x8 + x6;
    o[4] = x8 - x6; o[5] = x0 - x4; o[6] = x3 - x2; o[7] = x7 - x1;
    for (int k = 0; k < 8; k++) begin
      if (col) begin
        t = (o[k] >>> 14) + 128;
        o[k] = (t < 0) ? 0 : (t > 255) ? 255 : t;
      end else begin
        o[k] = o[k] >>> 8;
      end
    end
    return o;
  endfunction

  task automatic build_ref();
    v8_t v, o;
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) v[c] = coef[r*8+c];
      o = ref1d(v, 1'b0);
      for (int c = 0; c < 8; c++) rrow[r*8+c] = o[c];
    end
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) v[r] = rrow[r*8+c];
      o = ref1d(v, 1'b1);
      for (int r = 0; r < 8; r++) rpix[r*8+c] = o[r];
    end
  endtask

  // called on a falling edge, returns on the falling edge of the ack cycle
  task automatic xact(bit w, logic [9:0] a, logic [31:0] d);
    int n;
    sel_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!ack_o && n < 50);
    rd_v = rdata_o; last_cyc = n;
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(logic [9:0] a, int d);
    xact(1'b1, a, d);
  endtask

  task automatic rd(logic [9:0] a);
    xact(1'b0, a, '0);
  endtask

  // loads coef[], checks overlap (R5) and done timing (R7)
  task automatic load_block();
    for (int i = 0; i < 64; i++) begin
      wr(10'h100 + 10'(4*i), coef[i]);
      if (i % 8 == 7 && i < 63) begin
        rd(10'h200 + 10'(4*((i/8)*9)));
        check("R5 row ready after last write", int'(rd_v), rrow[(i/8)*9]);
      end
    end
    for (int k = 1; k <= 7; k++) begin
      rd(10'h000);
      check("R7 done timing", int'(rd_v), int'(k == 7));
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < 64; i++) begin
      rd(10'h200 + 10'(4*i));
      check("R4 row result", int'(rd_v), rrow[i]);
      rd(10'h300 + 10'(i));
      check("R6 pixel", int'(rd_v), rpix[i]);
    end
  endtask

  task automatic dc_block(int dc);
    for (int i = 0; i < 64; i++) coef[i] = 0;
    coef[0] = dc;
    build_ref();
    load_block();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 ack after reset", int'(ack_o), 0);
    check("R1 rdata after reset", int'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(10'h000);
    check("R1 done after reset", int'(rd_v), 0);
    rd(10'h32A);
    check("R1 pixel after reset", int'(rd_v), 0);

    // R2: from idle, then back to back
    repeat (3) @(negedge clk_i);
    rd(10'h000);
    check("R2 cycles from idle", last_cyc, 2);
    rd(10'h000);
    check("R2 cycles back to back", last_cyc, 3);

    // R3: coefficient window readback before row completes
    wr(10'h104, 32'h0000_1234);
    rd(10'h104);
    check("R3 coefficient readback", int'(rd_v), 32'h1234);

    // vector table walk
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < 64; i++) begin
        if (i == 0) coef[i] = TV[t][1];
        else if ((i / 8) + (i % 8) < TV[t][3])
          coef[i] = ((TV[t][0]*31 + i*i*17 + i*TV[t][0]) % (2*TV[t][2] + 1)) - TV[t][2];
        else coef[i] = 0;
      end
      build_ref();
      load_block();
      check_all();
    end

    // R9: writes outside coefficient window ignored
    wr(10'h204, 32'hDEAD_BEEF);
    rd(10'h204);
    check("R9 row window write ignored", int'(rd_v), rrow[1]);
    wr(10'h305, 32'h0000_00AA);
    rd(10'h305);
    check("R9 pixel window write ignored", int'(rd_v), rpix[5]);
    wr(10'h000, 32'h0);
    rd(10'h000);
    check("R9 status write ignored", int'(rd_v), 1);

    // R10: unmapped reads
    rd(10'h004);
    check("R10 unmapped 0x004", int'(rd_v), 0);
    rd(10'h340);
    check("R10 unmapped 0x340", int'(rd_v), 0);
    rd(10'h3FC);
    check("R10 unmapped 0x3FC", int'(rd_v), 0);

    // R8: write to first coefficient clears done
    wr(10'h100, 32'h0);
    rd(10'h000);
    check("R8 done cleared", int'(rd_v), 0);

    // R11: DC-only corner cases
    dc_block(80);
    rd(10'h200);
    check("R11 dc80 row value", int'(rd_v), 640);
    rd(10'h21C);
    check("R11 dc80 row value end", int'(rd_v), 640);
    rd(10'h2FC);
    check("R11 dc80 other row", int'(rd_v), 0);
    rd(10'h300);
    check("R11 dc80 pixel", int'(rd_v), 138);
    rd(10'h33F);
    check("R11 dc80 pixel last", int'(rd_v), 138);
    dc_block(2000);
    rd(10'h300);
    check("R11 saturate high", int'(rd_v), 255);
    rd(10'h31B);
    check("R11 saturate high mid", int'(rd_v), 255);
    dc_block(-2000);
    rd(10'h300);
    check("R11 saturate low", int'(rd_v), 0);
    rd(10'h33F);
    check("R11 saturate low last", int'(rd_v), 0);

    finish_run();
  end
endmodule